// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands of a configurable width and a one-bit carry-in, and returns the sum and the carry-out.

The operands are split into 4-bit slices. Inside each slice, every bit cell forms a local generate and a local propagate. A flattened lookahead network then derives all four in-slice carries directly from those terms and the slice carry-in, so no carry has to wait for the one below it. Each slice also reports a slice-wide propagate and a slice-wide generate.

A second-level lookahead unit takes those slice-wide terms together with the external carry-in. It produces the carry entering every slice and the final carry-out in one step, so carries never ripple from one slice to the next. The block is used wherever a wide add must settle within one clock period and a rippled chain would be too slow.

Top module: `cla_adder2l`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `opd_a + opd_b + carry_in`, for every operand pair and carry-in.
- R2: `carry_out` equals bit WIDTH of `opd_a + opd_b + carry_in`.
- R3: When `opd_a` and `opd_b` share no set bit and `carry_in` is 0, `sum_out` equals `opd_a ^ opd_b` and `carry_out` is 0, because no bit generates a carry.
- R4: When `opd_b` is the bitwise complement of `opd_a`, every bit propagates. With `carry_in` = 0 the result is an all-ones sum with `carry_out` = 0. With `carry_in` = 1 it is an all-zero sum with `carry_out` = 1.
- R5: A carry generated at the top bit of a 4-bit slice enters the next slice. Setting only bit 4k+3 in both operands gives a sum with only bit 4k+4 set, or, for the top slice, a zero sum with `carry_out` = 1.
- R6: Adding one to the all-ones operand, either through `carry_in` or through `opd_b` = 1, gives a zero sum with `carry_out` = 1. Adding one to an all-zero operand gives a sum of 1 with `carry_out` = 0.
- R7: The carry into each slice, as formed by the second-level unit, equals that of the serial recurrence c(i+1) = G(i) | (P(i) & c(i)) over the slice terms. In that recurrence, a slice's propagate is the AND of its four bit propagates, and its generate is set when a carry leaves its top bit. A slice never reports propagate and generate together. For example, 0x0FFF + 0x0001 carries through three slices to give 0x1000.
- R8: WIDTH is a multiple of 4, with a default of 16. The adder is correct for every such width, including 8 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | WIDTH | First addend |
| opd_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder three times: with WIDTH = 8, the default 16, and 32.

At 8 bits the whole input space of 2^17 combinations is swept, so every slice and lookahead term is covered exhaustively. The 16-bit instance carries the directed corner cases: full propagate, slice-boundary generate and the longest carry paths. The 32-bit instance puts eight slices on the second-level unit, which reaches the deepest expanded carry terms, and it takes random vectors on top of the same corners.

// File: rtl/cla2l_pkg.sv
package cla2l_pkg;

    localparam int GRP_W = 4;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    function automatic pg_t make_pg(input logic x, input logic y);
        pg_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

endpackage

// File: rtl/cla2l_bit_cell.sv
module cla2l_bit_cell
    import cla2l_pkg::*;
(
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output pg_t  pg_out,
    output logic s_out
);

    assign pg_out = make_pg(x_in, y_in);
    assign s_out  = (x_in ^ y_in) ^ c_in;

endmodule

// File: rtl/cla2l_group4.sv
module cla2l_group4
    import cla2l_pkg::*;
(
    input  logic [GRP_W-1:0] x_in,
    input  logic [GRP_W-1:0] y_in,
    input  logic             c_in,
    output logic [GRP_W-1:0] s_out,
    output pg_t              grp_out
);

    pg_t  [GRP_W-1:0] bit_pg;
    logic [GRP_W:0]   cy;

    for (genvar i = 0; i < GRP_W; i++) begin : g_cell
        cla2l_bit_cell u_cell (
            .x_in   (x_in[i]),
            .y_in   (y_in[i]),
            .c_in   (cy[i]),
            .pg_out (bit_pg[i]),
            .s_out  (s_out[i])
        );
    end

    // Flattened carries: each term is a generate (or c_in) ANDed with the propagates above it.
    always_comb begin
        for (int k = 0; k <= GRP_W; k++) begin
            logic acc;
            acc = c_in;
            for (int m = 0; m < k; m++) acc = acc & bit_pg[m].prop;
            for (int j = 0; j < k; j++) begin
                logic term;
                term = bit_pg[j].gen;
                for (int m = j + 1; m < k; m++) term = term & bit_pg[m].prop;
                acc = acc | term;
            end
            cy[k] = acc;
        end
    end

    // Slice terms depend only on the operands, never on c_in.
    always_comb begin
        logic gp, gg;
        gp = 1'b1;
        gg = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            gg = bit_pg[i].gen | (bit_pg[i].prop & gg);
            gp = gp & bit_pg[i].prop;
        end
        grp_out.prop = gp;
        grp_out.gen  = gg;
    end

    always_comb begin
        AST_GRP_CARRY: assert (cy[GRP_W] == (grp_out.gen | (grp_out.prop & c_in))); // R7
        AST_GRP_EXCL:  assert (!(grp_out.prop && grp_out.gen)); // R7
    end

endmodule

// File: rtl/cla2l_lookahead.sv
module cla2l_lookahead
    import cla2l_pkg::*;
#(
    parameter int NGRP = 4
) (
    input  pg_t [NGRP-1:0] grp_in,
    input  logic           c_in,
    output logic [NGRP:0]  c_out
);

    always_comb begin
        for (int k = 0; k <= NGRP; k++) begin
            logic acc;
            acc = c_in;
            for (int m = 0; m < k; m++) acc = acc & grp_in[m].prop;
            for (int j = 0; j < k; j++) begin
                logic term;
                term = grp_in[j].gen;
                for (int m = j + 1; m < k; m++) term = term & grp_in[m].prop;
                acc = acc | term;
            end
            c_out[k] = acc;
        end
    end

    always_comb begin
        AST_LA_BASE: assert (c_out[0] == c_in); // R7
        for (int i = 0; i < NGRP; i++) begin
            AST_LA_RECUR: assert (c_out[i+1] == (grp_in[i].gen | (grp_in[i].prop & c_out[i]))); // R7
        end
    end

endmodule

// File: rtl/cla_adder2l.sv
module cla_adder2l
    import cla2l_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NGRP = WIDTH / GRP_W;

    pg_t  [NGRP-1:0] grp_pg;
    logic [NGRP:0]   grp_c;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        cla2l_group4 u_grp (
            .x_in    (opd_a[g*GRP_W +: GRP_W]),
            .y_in    (opd_b[g*GRP_W +: GRP_W]),
            .c_in    (grp_c[g]),
            .s_out   (sum_out[g*GRP_W +: GRP_W]),
            .grp_out (grp_pg[g])
        );
    end

    cla2l_lookahead #(.NGRP(NGRP)) u_la (
        .grp_in (grp_pg),
        .c_in   (carry_in),
        .c_out  (grp_c)
    );

    assign carry_out = grp_c[NGRP];

    always_comb begin
        logic [WIDTH:0] ref_sum;
        ref_sum = {1'b0, opd_a} + {1'b0, opd_b} + {{WIDTH{1'b0}}, carry_in};
        AST_SUM_EXACT:  assert (sum_out == ref_sum[WIDTH-1:0]); // R1
        AST_COUT_EXACT: assert (carry_out == ref_sum[WIDTH]); // R2
    end

endmodule

// File: tb/test_cla_adder2l.sv
module test_cla_adder2l;

    logic clk = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    cla_adder2l i_cla_adder2l (
        .opd_a(a16), .opd_b(b16), .carry_in(c16), .sum_out(s16), .carry_out(co16));
    cla_adder2l #(.WIDTH(8)) i_cla_adder2l_w8 (
        .opd_a(a8), .opd_b(b8), .carry_in(c8), .sum_out(s8), .carry_out(co8));
    cla_adder2l #(.WIDTH(32)) i_cla_adder2l_w32 (
        .opd_a(a32), .opd_b(b32), .carry_in(c32), .sum_out(s32), .carry_out(co32));

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c);
        a16 = a; b16 = b; c16 = c;
        #1;
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c);
        a32 = a; b32 = b; c32 = c;
        #1;
    endtask

    task automatic t_zero;
        apply16(16'h0, 16'h0, 1'b0);
        chk("R1 zero sum", {48'h0, s16}, 64'h0);
        chk("R2 zero cout", {63'h0, co16}, 64'h0);
    endtask

    task automatic t_disjoint;
        logic [15:0] pa [3] = '{16'hA5A5, 16'h0F0F, 16'h8001};
        for (int i = 0; i < 3; i++) begin
            apply16(pa[i], ~pa[i] & 16'h3C3C, 1'b0);
            chk("R3 disjoint sum", {48'h0, s16}, {48'h0, pa[i] ^ (~pa[i] & 16'h3C3C)});
            chk("R3 disjoint cout", {63'h0, co16}, 64'h0);
        end
    endtask

    task automatic t_full_prop;
        logic [15:0] pa [3] = '{16'h0000, 16'h5A3C, 16'hFFFF};
        for (int i = 0; i < 3; i++) begin
            apply16(pa[i], ~pa[i], 1'b0);
            chk("R4 prop cin0 sum", {48'h0, s16}, {48'h0, 16'hFFFF});
            chk("R4 prop cin0 cout", {63'h0, co16}, 64'h0);
            apply16(pa[i], ~pa[i], 1'b1);
            chk("R4 prop cin1 sum", {48'h0, s16}, 64'h0);
            chk("R4 prop cin1 cout", {63'h0, co16}, 64'h1);
        end
        apply32(32'h1234_5678, ~32'h1234_5678, 1'b1);
        chk("R4 prop w32 sum", {32'h0, s32}, 64'h0);
        chk("R4 prop w32 cout", {63'h0, co32}, 64'h1);
    endtask

    task automatic t_group_gen;
        for (int k = 0; k < 4; k++) begin
            logic [16:0] e;
            e = 17'h1 << (4*k + 4);
            apply16(16'h1 << (4*k + 3), 16'h1 << (4*k + 3), 1'b0);
            chk("R5 slice gen sum", {48'h0, s16}, {48'h0, e[15:0]});
            chk("R5 slice gen cout", {63'h0, co16}, {63'h0, e[16]});
        end
    endtask

    task automatic t_multi_slice;
        apply16(16'h0FFF, 16'h0001, 1'b0);
        chk("R7 three-slice carry sum", {48'h0, s16}, {48'h0, 16'h1000});
        apply16(16'h00F8, 16'h0008, 1'b0);
        chk("R7 slice1 pass sum", {48'h0, s16}, {48'h0, 16'h0100});
        apply32(32'h0FFF_FFF0, 32'h0000_0010, 1'b0);
        chk("R7 w32 six-slice sum", {32'h0, s32}, {32'h0, 32'h1000_0000});
        chk("R7 w32 cout", {63'h0, co32}, 64'h0);
    endtask

    task automatic t_longest;
        apply16(16'hFFFF, 16'h0000, 1'b1);
        chk("R6 ones+cin sum", {48'h0, s16}, 64'h0);
        chk("R6 ones+cin cout", {63'h0, co16}, 64'h1);
        apply16(16'hFFFF, 16'h0001, 1'b0);
        chk("R6 ones+1 sum", {48'h0, s16}, 64'h0);
        chk("R6 ones+1 cout", {63'h0, co16}, 64'h1);
        apply16(16'h0000, 16'h0001, 1'b0);
        chk("R6 zero+1 sum", {48'h0, s16}, 64'h1);
        chk("R6 zero+1 cout", {63'h0, co16}, 64'h0);
        apply32(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R6 w32 ones+cin sum", {32'h0, s32}, 64'h0);
        chk("R6 w32 ones+cin cout", {63'h0, co32}, 64'h1);
    endtask

    task automatic t_exhaustive_w8;
        int bad;
        bad = 0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] e;
                    a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
                    #1;
                    e = {1'b0, a8} + {1'b0, b8} + {8'h0, c8};
                    if (bad < 4 || {co8, s8} == e) chk("R8 w8 exhaustive", {55'h0, co8, s8}, {55'h0, e});
                    else begin n_run++; n_fail++; end
                    if ({co8, s8} != e) bad++;
                end
            end
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 2000; i++) begin
            logic [16:0] e16;
            logic [32:0] e32;
            apply16($urandom(), $urandom(), $urandom() % 2 == 1);
            e16 = {1'b0, a16} + {1'b0, b16} + {16'h0, c16};
            chk("R1 w16 random sum", {48'h0, s16}, {48'h0, e16[15:0]});
            chk("R2 w16 random cout", {63'h0, co16}, {63'h0, e16[16]});
            apply32($urandom(), $urandom(), $urandom() % 2 == 1);
            e32 = {1'b0, a32} + {1'b0, b32} + {32'h0, c32};
            chk("R1 w32 random sum", {32'h0, s32}, {32'h0, e32[31:0]});
            chk("R2 w32 random cout", {63'h0, co32}, {63'h0, e32[32]});
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        @(negedge clk);
        t_zero();
        t_disjoint();
        t_full_prop();
        t_group_gen();
        t_multi_slice();
        t_longest();
        t_exhaustive_w8();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule